// File: doc/BRIEF.md
# Receive-Side Transaction Reorder Buffer

This block sits on the receive side of a transaction layer. Packets arrive one per cycle, and each carries a class code, a relaxed-ordering flag, a transaction tag and one payload word. The block holds them in three class queues: posted writes and messages, non-posted requests, and completions. One downstream port drains the queues under producer-consumer ordering rules.

The consumer raises a per-class room signal for each class it can take in the current cycle. A queue head is a candidate only when its class has room and the ordering rules allow it to overtake what is still queued. Posted traffic is never held back by the other two classes. Non-posted requests wait behind every older posted packet. Completions wait behind older posted packets unless their relaxed flag is set. Among the candidates, the oldest packet is emitted.

Age is tracked without a wrapping sequence counter. When an entry arrives it records, for each other class, how many packets of that class are already queued. Each departure of that class lowers the count by one. A head whose count for another class has reached zero is older than every packet still queued in that class.

Top module: `rx_order_rob`

## Requirements
- R1: During and right after reset, every queue is empty, `out_valid` is low and `in_ready` is 3'b111.
- R2: Class codes are 0 for posted, 1 for non-posted and 2 for completion. A packet with `in_valid` high and a class code of 3 is discarded and never appears at the output.
- R3: `in_ready[c]` is low exactly when queue c holds DEPTH packets. A full class does not stop the other classes from being accepted.
- R4: Within one class, packets leave in the order they arrived. This keeps non-relaxed posted writes in order, keeps non-posted requests in order and keeps completions that share a tag in order.
- R5: A queued posted packet is emitted whenever `dn_room[0]` is high and no older eligible head exists. It never waits for non-posted or completion heads.
- R6: A non-posted request is not emitted while an older posted packet is still queued.
- R7: A completion with its relaxed flag clear is not emitted while an older posted packet is queued. With the flag set, it may overtake that packet.
- R8: A head is eligible only when the room bit of its class is high. Of the eligible heads, the one that arrived first is emitted.
- R9: `out_valid` is high exactly when an eligible head exists, and the output fields show that packet. While `out_ready` is low and `dn_room` is unchanged, the offer stays the same.
- R10: A packet leaves its queue only in a cycle with `out_valid` and `out_ready` both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming packet present |
| in_cls | input | 2 | Incoming class code (0 posted, 1 non-posted, 2 completion) |
| in_ro | input | 1 | Relaxed-ordering flag of the incoming packet |
| in_tid | input | 8 | Transaction tag |
| in_data | input | 16 | Payload word |
| in_ready | output | 3 | Per-class space available, one bit per class code |
| dn_room | input | 3 | Per-class acceptance capability of the consumer |
| out_ready | input | 1 | Consumer takes the offered packet |
| out_valid | output | 1 | A packet is offered |
| out_cls | output | 2 | Class code of the offered packet |
| out_ro | output | 1 | Relaxed flag of the offered packet |
| out_tid | output | 8 | Tag of the offered packet |
| out_data | output | 16 | Payload of the offered packet |

## Verification
The queues are the only state, and the output is decoded from their heads and `dn_room` in the same cycle. A packet accepted at one rising edge can therefore be offered from that edge on. `in_ready` shows the new fill level after the same edge, and a departure frees its slot at the edge where `out_ready` is sampled high. The bench drives inputs just after the falling edge and compares outputs one time unit later, against a model that holds every queued packet with its arrival number. It updates that model only after the next rising edge, using the accept and take decisions it made for that cycle.

// File: rtl/rx_order_pkg.sv
package rx_order_pkg;

    localparam int RX_DATA_W  = 16;
    localparam int RX_TID_W   = 8;
    localparam int RX_DEPTH   = 8;
    localparam int RX_NCLS    = 3;
    localparam int RX_AHEAD_W = $clog2(RX_DEPTH + 1);

    typedef enum logic [1:0] {
        CLS_POST = 2'd0,
        CLS_NP   = 2'd1,
        CLS_CPL  = 2'd2,
        CLS_NONE = 2'd3
    } tlp_cls_e;

    // ahead[c]: packets of class c still queued that arrived before this one
    typedef struct packed {
        logic                                 ro;
        logic [RX_TID_W-1:0]                  tid;
        logic [RX_DATA_W-1:0]                 data;
        logic [RX_NCLS-1:0][RX_AHEAD_W-1:0]   ahead;
    } rx_entry_t;

    function automatic logic has_older(rx_entry_t e, int unsigned cls);
        return e.ahead[cls] != '0;
    endfunction

endpackage

// File: rtl/rx_class_queue.sv
module rx_class_queue
    import rx_order_pkg::*;
#(
    parameter int DEPTH   = RX_DEPTH,
    parameter int CLS_IDX = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  rx_entry_t                  push_ent,
    input  logic                       pop,
    input  logic [RX_NCLS-1:0]         pop_mask,
    output rx_entry_t                  head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t         mem [DEPTH];
    logic [PW-1:0]     wp_q, rp_q;
    logic [CW-1:0]     cnt_q;

    function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            // age counters shrink as older packets of other classes leave
            for (int i = 0; i < DEPTH; i++) begin
                for (int c = 0; c < RX_NCLS; c++) begin
                    if (c != CLS_IDX && pop_mask[c] && mem[i].ahead[c] != '0)
                        mem[i].ahead[c] <= mem[i].ahead[c] - 1'b1;
                end
            end
            if (push) begin
                mem[wp_q] <= push_ent;
                wp_q      <= nxt(wp_q);
            end
            if (pop) rp_q <= nxt(rp_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rp_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign count = cnt_q;

endmodule

// File: rtl/rx_order_arb.sv
module rx_order_arb
    import rx_order_pkg::*;
(
    input  rx_entry_t           head [RX_NCLS],
    input  logic [RX_NCLS-1:0]  hvalid,
    input  logic [RX_NCLS-1:0]  room,
    output logic [RX_NCLS-1:0]  grant
);
    logic [RX_NCLS-1:0] elig;

    always_comb begin
        // posted: never blocked by other classes
        elig[CLS_POST] = hvalid[CLS_POST] && room[CLS_POST];
        // non-posted: must not overtake any older posted packet
        elig[CLS_NP]   = hvalid[CLS_NP] && room[CLS_NP] &&
                         !has_older(head[CLS_NP], CLS_POST);
        // completion: may overtake posted only when relaxed
        elig[CLS_CPL]  = hvalid[CLS_CPL] && room[CLS_CPL] &&
                         (head[CLS_CPL].ro || !has_older(head[CLS_CPL], CLS_POST));
    end

    // oldest eligible head wins: no eligible head of another class is older
    always_comb begin
        for (int i = 0; i < RX_NCLS; i++) begin
            grant[i] = elig[i];
            for (int j = 0; j < RX_NCLS; j++) begin
                if (j != i && elig[j] && has_older(head[i], j))
                    grant[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/rx_order_rob.sv
module rx_order_rob
    import rx_order_pkg::*;
#(
    parameter int DEPTH = RX_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [1:0]            in_cls,
    input  logic                  in_ro,
    input  logic [RX_TID_W-1:0]   in_tid,
    input  logic [RX_DATA_W-1:0]  in_data,
    output logic [RX_NCLS-1:0]    in_ready,
    input  logic [RX_NCLS-1:0]    dn_room,
    input  logic                  out_ready,
    output logic                  out_valid,
    output logic [1:0]            out_cls,
    output logic                  out_ro,
    output logic [RX_TID_W-1:0]   out_tid,
    output logic [RX_DATA_W-1:0]  out_data
);
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t          head_q [RX_NCLS];
    logic [CW-1:0]      cnt_q  [RX_NCLS];
    logic [RX_NCLS-1:0] empty_q, full_q, push_c, pop_c, grant;

    for (genvar g = 0; g < RX_NCLS; g++) begin : g_cls
        rx_entry_t ent;

        assign push_c[g] = in_valid && (in_cls == 2'(g)) && !full_q[g];

        always_comb begin
            ent.ro   = in_ro;
            ent.tid  = in_tid;
            ent.data = in_data;
            for (int c = 0; c < RX_NCLS; c++) begin
                if (c == g) ent.ahead[c] = '0;
                else        ent.ahead[c] = RX_AHEAD_W'(cnt_q[c]) - RX_AHEAD_W'(pop_c[c]);
            end
        end

        rx_class_queue #(.DEPTH(DEPTH), .CLS_IDX(g)) q_i (
            .clk      (clk),
            .rst      (rst),
            .push     (push_c[g]),
            .push_ent (ent),
            .pop      (pop_c[g]),
            .pop_mask (pop_c),
            .head     (head_q[g]),
            .empty    (empty_q[g]),
            .full     (full_q[g]),
            .count    (cnt_q[g])
        );
    end

    rx_order_arb arb_i (
        .head   (head_q),
        .hvalid (~empty_q),
        .room   (dn_room),
        .grant  (grant)
    );

    assign pop_c    = grant & {RX_NCLS{out_ready}};
    assign in_ready = ~full_q;

    always_comb begin
        out_valid = |grant;
        out_cls   = CLS_NONE;
        out_ro    = 1'b0;
        out_tid   = '0;
        out_data  = '0;
        for (int c = 0; c < RX_NCLS; c++) begin
            if (grant[c]) begin
                out_cls  = 2'(c);
                out_ro   = head_q[c].ro;
                out_tid  = head_q[c].tid;
                out_data = head_q[c].data;
            end
        end
    end

endmodule

// File: rtl/rx_order_rob_chk.sv
module rx_order_rob_chk
    import rx_order_pkg::*;
#(
    parameter int DEPTH = RX_DEPTH
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [1:0]           in_cls,
    input logic [RX_NCLS-1:0]   in_ready,
    input logic [RX_NCLS-1:0]   dn_room,
    input logic                 out_ready,
    input logic                 out_valid,
    input logic [1:0]           out_cls,
    input logic [RX_TID_W-1:0]  out_tid,
    input logic [RX_DATA_W-1:0] out_data
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] ck_cnt [RX_NCLS];

    always_ff @(posedge clk) begin
        for (int c = 0; c < RX_NCLS; c++) begin
            if (rst) ck_cnt[c] <= '0;
            else ck_cnt[c] <= ck_cnt[c]
                 + CW'(in_valid && in_cls == 2'(c) && in_ready[c])
                 - CW'(out_valid && out_ready && out_cls == 2'(c));
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (in_ready == 3'b111 && !out_valid));

    for (genvar g = 0; g < RX_NCLS; g++) begin : g_ck
        // R3
        full_ready_chk: assert property (@(posedge clk) disable iff (rst)
            in_ready[g] == (ck_cnt[g] != CW'(DEPTH)));
    end

    // R9
    idle_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (ck_cnt[0] == '0 && ck_cnt[1] == '0 && ck_cnt[2] == '0) |-> !out_valid);

    // R8
    room_gate_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_cls != CLS_NONE && dn_room[out_cls]));

    // R5
    post_progress_chk: assert property (@(posedge clk) disable iff (rst)
        (ck_cnt[0] != '0 && dn_room[0]) |-> out_valid);

    // R9
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) ##1 (dn_room == $past(dn_room)) |->
        (out_valid && $stable(out_cls) && $stable(out_tid) && $stable(out_data)));

endmodule

bind rx_order_rob rx_order_rob_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/rx_order_rob_tb_top.sv
module rx_order_rob_tb_top;
    import rx_order_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = RX_DEPTH;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [1:0]           in_cls = 2'd0;
    logic                 in_ro = 1'b0;
    logic [RX_TID_W-1:0]  in_tid = '0;
    logic [RX_DATA_W-1:0] in_data = '0;
    logic [2:0]           in_ready;
    logic [2:0]           dn_room = 3'b000;
    logic                 out_ready = 1'b0;
    logic                 out_valid;
    logic [1:0]           out_cls;
    logic                 out_ro;
    logic [RX_TID_W-1:0]  out_tid;
    logic [RX_DATA_W-1:0] out_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_order_rob #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_ro(in_ro),
        .in_tid(in_tid), .in_data(in_data), .in_ready(in_ready), .dn_room(dn_room),
        .out_ready(out_ready), .out_valid(out_valid), .out_cls(out_cls),
        .out_ro(out_ro), .out_tid(out_tid), .out_data(out_data)
    );

    typedef struct { int seq; bit ro; int tid; int data; } mpkt_t;
    mpkt_t mq [3][$];
    int    n_chk = 0, n_fail = 0, seq_ctr = 0;
    bit    done = 1'b0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_pick(logic [2:0] room);
        int best = -1;
        int bseq = 0;
        for (int c = 0; c < 3; c++) begin
            if (room[c] && mq[c].size() > 0) begin
                bit ok = 1'b1;
                mpkt_t h = mq[c][0];
                if (c != 0 && mq[0].size() > 0 && mq[0][0].seq < h.seq && (c == 1 || !h.ro))
                    ok = 1'b0;
                if (ok && (best < 0 || h.seq < bseq)) begin
                    best = c;
                    bseq = h.seq;
                end
            end
        end
        return best;
    endfunction

    task automatic step(bit iv, int icls, bit iro, int itid, logic [2:0] room, bit ordy);
        int pick;
        bit acc;
        logic [2:0] erdy;
        mpkt_t p;
        @(negedge clk);
        in_valid  = iv;
        in_cls    = 2'(icls);
        in_ro     = iro;
        in_tid    = RX_TID_W'(itid);
        in_data   = RX_DATA_W'(seq_ctr);
        dn_room   = room;
        out_ready = ordy;
        #1;
        pick = exp_pick(room);
        for (int c = 0; c < 3; c++) erdy[c] = (mq[c].size() < DEPTH);
        chk(in_ready == erdy, "R3 in_ready", int'(in_ready), int'(erdy));
        chk(out_valid == (pick >= 0), "R9/R10 out_valid", int'(out_valid), int'(pick >= 0));
        if (pick >= 0 && out_valid) begin
            p = mq[pick][0];
            case (pick)
                0:       chk(out_cls == 2'd0 && out_data == RX_DATA_W'(p.data), "R4/R5/R8 posted", int'(out_data), p.data);
                1:       chk(out_cls == 2'd1 && out_data == RX_DATA_W'(p.data), "R4/R6/R8 nonposted", int'(out_data), p.data);
                default: chk(out_cls == 2'd2 && out_data == RX_DATA_W'(p.data), "R4/R7/R8 completion", int'(out_data), p.data);
            endcase
            chk(out_tid == RX_TID_W'(p.tid) && out_ro == p.ro, "R9 fields", int'(out_tid), p.tid);
        end
        acc = iv && icls < 3 && mq[icls].size() < DEPTH;
        @(posedge clk);
        // R10: the model removes a packet only when the consumer took it
        if (pick >= 0 && ordy) void'(mq[pick].pop_front());
        if (acc) begin
            p.seq = seq_ctr; p.ro = iro; p.tid = itid; p.data = seq_ctr & 16'hFFFF;
            mq[icls].push_back(p);
        end
        seq_ctr++;
    endtask

    task automatic drain();
        int guard = 0;
        while ((mq[0].size() + mq[1].size() + mq[2].size()) > 0 && guard < 200) begin
            step(0, 0, 0, 0, 3'b111, 1);
            guard++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: outputs while reset is held
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(in_ready == 3'b111, "R1 in_ready in reset", int'(in_ready), 7);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        // R2: class code 3 is dropped
        step(1, 3, 0, 5, 3'b111, 1);
        step(0, 0, 0, 0, 3'b111, 1);
        #1;
        chk(out_valid == 1'b0, "R2 dropped class", int'(out_valid), 0);

        // R3: fill non-posted with consumer closed, posted still accepted
        for (int i = 0; i < DEPTH; i++) step(1, 1, 0, i, 3'b000, 0);
        #1;
        chk(in_ready[1] == 1'b0, "R3 np full", int'(in_ready[1]), 0);
        chk(in_ready[0] == 1'b1, "R3 posted open", int'(in_ready[0]), 1);
        step(1, 0, 0, 9, 3'b000, 0);
        step(1, 1, 0, 9, 3'b000, 0);
        // R5: posted leaves while non-posted has no room
        step(0, 0, 0, 0, 3'b001, 1);
        drain();

        // R6: non-posted waits for an older posted packet
        step(1, 0, 0, 1, 3'b000, 0);
        step(1, 1, 0, 2, 3'b010, 1);
        step(0, 0, 0, 0, 3'b010, 1);
        #1;
        chk(out_valid == 1'b0, "R6 np held", int'(out_valid), 0);
        drain();

        // R7: relaxed completion overtakes, strict one waits
        step(1, 0, 0, 1, 3'b000, 0);
        step(1, 2, 1, 3, 3'b000, 0);
        step(1, 2, 0, 4, 3'b000, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 3'b100, 1);
        #1;
        chk(out_valid == 1'b0, "R7 strict cpl held", int'(out_valid), 0);
        chk(mq[2].size() == 1, "R7 relaxed cpl gone", mq[2].size(), 1);
        drain();

        // R4: completions sharing a tag keep arrival order
        for (int i = 0; i < 4; i++) step(1, 2, i % 2, 7, 3'b000, 0);
        drain();

        // sweep of room patterns and traffic mixes
        for (int mode = 0; mode < 16; mode++) begin
            for (int n = 0; n < 1200; n++) begin
                logic [2:0] rm = 3'($urandom) | 3'(mode & 7);
                if (mode >= 8) rm = rm & 3'($urandom);
                step($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 1),
                     $urandom_range(0, 3), rm, $urandom_range(0, 3) != 0);
            end
            drain();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule